// File: doc/BRIEF.md
# Fetch Stall-Vector Gating Predictor

This block sits next to the target buffer of an in-order instruction front end. It keeps a small set-associative table, indexed by fetch-group address. Each entry holds a short count of idle cycles to insert before that group is fetched. Long dispatch stalls that would otherwise happen all at once are spread into single-cycle fetch gaps, which lets the front-end latches stay quiet. A 4-bit saturating confidence counter guards each count. Only entries whose confidence is above a threshold delay fetch.

Each accepted lookup produces one fetch pulse on `fetch_go`. Before the pulse, the output stays low for the predicted number of idle cycles. A 16-bit LFSR occasionally picks a confident lookup to run without delay. That run is flagged on `probe_run` so the core can compare its timing with the delayed run. The core reports back on the training port with the stall count it observed and a flag that says whether the delayed fetch slowed execution. Training bumps confidence, reloads the count on a wrong prediction, or allocates a new entry on a miss.

Top module: `fetch_stall_gate`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `fetch_go` and `probe_run` are low and every table entry is invalid. Every lookup therefore misses until it is trained.
- R2: When a lookup misses, or hits an entry whose confidence is 4 or less, `fetch_go` is high in the cycle right after the lookup is accepted, with no idle cycles inserted.
- R3: Fetch groups are 4 instructions of 4 bytes each. The set index is `pc[4 +: log2(SETS)]` and the tag is every PC bit above the index. PCs that differ only in bits 3:0 share one entry. PCs in the same set with different tags are separate entries.
- R4: A training update for a PC that misses allocates an entry with confidence 0, the reported stall count as its vector, and the PC's tag. The entry goes to the lowest-numbered invalid way of the set. If all ways are valid, it goes to the way named by a per-set round-robin pointer that starts at 0. That pointer advances by one, modulo WAYS, only when it was used.
- R5: A training update that hits with `train_slow` low increments the confidence by 1, saturating at 15, and leaves the vector unchanged.
- R6: A training update that hits with `train_slow` high clears the confidence to 0 and loads `train_stalls` into the vector.
- R7: A lookup that is accepted, hits, finds confidence above 4 (the `THRESH` parameter) and is not sampled keeps `fetch_go` low for exactly the stored vector count of cycles. It then drives `fetch_go` high for one cycle. A vector of 0 gives the pulse in the next cycle.
- R8: A 16-bit LFSR starts at 0xACE1 and steps once per accepted lookup, to `{l[14:0], l[15]^l[13]^l[12]^l[10]}`. A lookup is sampled when the LFSR value before the step has its low byte below 26. A sampled lookup that would have been gated fetches in the next cycle instead, and `probe_run` is high in that same cycle.
- R9: A lookup is accepted only when no idle count is in progress. A lookup presented while a count runs is ignored: it does not step the LFSR and does not produce a pulse.
- R10: When a lookup and a training update occur in the same cycle, the lookup sees the table as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A fetch group asks to be fetched |
| lookup_pc | input | PC_W | Address of the requesting fetch group |
| train_valid | input | 1 | Training update from the core |
| train_pc | input | PC_W | Address of the group being trained |
| train_stalls | input | STALL_W | Stall cycles the core observed for that group |
| train_slow | input | 1 | Delayed fetch made execution longer than the ungated run |
| fetch_go | output | 1 | One-cycle pulse that lets the group be fetched |
| probe_run | output | 1 | The current pulse is a sampled run with no delay |

## Verification
A corrupted confidence counter or vector shows up on the next lookup of that group. It appears as a `fetch_go` pulse that comes early or late, or as a `probe_run` where none is due, within at most eight cycles of acceptance. A wrong replacement choice or index slice stays hidden until a later lookup of the evicted or aliased group. For that reason the mixed phase crowds more groups into one set than it has ways. An LFSR that drifts by even one step moves every later probe. This is seen over the long run of lookups on a confident group, where the model predicts every probe cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   localparam int CONF_W = 4;
   typedef logic [CONF_W-1:0] conf_t;
   localparam conf_t CONF_SAT = '1;
   typedef enum logic [1:0] {UPD_NONE, UPD_BUMP, UPD_RELOAD, UPD_ALLOC} upd_e;
endpackage

// File: rtl/fsg_lfsr.sv
module fsg_lfsr #(
   parameter int          LW   = 16,
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [LW-1:0] state
);
   logic fb;
   assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state <= SEED;
      else if (step)  state <= {state[LW-2:0], fb};
   end
endmodule

// File: rtl/fsg_table.sv
module fsg_table
   import fsg_pkg::*;
#(
   parameter int SETS    = 64,
   parameter int WAYS    = 4,
   parameter int PC_W    = 32,
   parameter int OFF     = 4,
   parameter int STALL_W = 3,
   parameter int THRESH  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PC_W-1:0]    rd_pc,
   output logic               rd_hit,
   output logic               rd_sure,
   output logic [STALL_W-1:0] rd_vec,
   input  logic               wr_valid,
   input  logic [PC_W-1:0]    wr_pc,
   input  logic [STALL_W-1:0] wr_stalls,
   input  logic               wr_slow
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = PC_W - OFF - IDX_W;
   localparam int WAY_W = $clog2(WAYS);

   logic               tab_v    [SETS][WAYS];
   logic [TAG_W-1:0]   tab_tag  [SETS][WAYS];
   logic [STALL_W-1:0] tab_vec  [SETS][WAYS];
   conf_t              tab_conf [SETS][WAYS];
   logic [WAY_W-1:0]   tab_rr   [SETS];

   logic [IDX_W-1:0] rd_set, wr_set;
   logic [TAG_W-1:0] rd_tag, wr_tag;
   assign rd_set = rd_pc[OFF +: IDX_W];
   assign rd_tag = rd_pc[PC_W-1 -: TAG_W];
   assign wr_set = wr_pc[OFF +: IDX_W];
   assign wr_tag = wr_pc[PC_W-1 -: TAG_W];

   logic [WAYS-1:0] rd_match, wr_match, wr_free;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign rd_match[w] = tab_v[rd_set][w] && (tab_tag[rd_set][w] == rd_tag);
         assign wr_match[w] = tab_v[wr_set][w] && (tab_tag[wr_set][w] == wr_tag);
         assign wr_free[w]  = !tab_v[wr_set][w];
      end
   endgenerate

   conf_t rd_conf;
   always_comb begin
      rd_hit  = 1'b0;
      rd_vec  = '0;
      rd_conf = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rd_match[w]) begin
            rd_hit  = 1'b1;
            rd_vec  = tab_vec[rd_set][w];
            rd_conf = tab_conf[rd_set][w];
         end
      end
   end
   assign rd_sure = rd_hit && (rd_conf > conf_t'(THRESH));

   logic             wr_hit, any_free;
   logic [WAY_W-1:0] hit_way, free_way, tgt_way;
   upd_e             op;

   always_comb begin
      wr_hit   = 1'b0;
      hit_way  = '0;
      any_free = 1'b0;
      free_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (wr_match[w]) begin
            wr_hit  = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (wr_free[w]) begin
            any_free = 1'b1;
            free_way = WAY_W'(w);
         end
      end
      if (wr_hit)        tgt_way = hit_way;
      else if (any_free) tgt_way = free_way;
      else               tgt_way = tab_rr[wr_set];
      if (!wr_valid)     op = UPD_NONE;
      else if (wr_hit)   op = wr_slow ? UPD_RELOAD : UPD_BUMP;
      else               op = UPD_ALLOC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            tab_rr[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               tab_v[s][w]    <= 1'b0;
               tab_tag[s][w]  <= '0;
               tab_vec[s][w]  <= '0;
               tab_conf[s][w] <= '0;
            end
         end
      end else begin
         unique case (op)
            UPD_BUMP: begin
               if (tab_conf[wr_set][tgt_way] != CONF_SAT)
                  tab_conf[wr_set][tgt_way] <= tab_conf[wr_set][tgt_way] + 1'b1;
            end
            UPD_RELOAD: begin
               tab_conf[wr_set][tgt_way] <= '0;
               tab_vec[wr_set][tgt_way]  <= wr_stalls;
            end
            UPD_ALLOC: begin
               tab_v[wr_set][tgt_way]    <= 1'b1;
               tab_tag[wr_set][tgt_way]  <= wr_tag;
               tab_vec[wr_set][tgt_way]  <= wr_stalls;
               tab_conf[wr_set][tgt_way] <= '0;
               if (!any_free) tab_rr[wr_set] <= tab_rr[wr_set] + 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fsg_pacer.sv
module fsg_pacer #(
   parameter int STALL_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [STALL_W-1:0] len,
   input  logic               probe_in,
   output logic               idle,
   output logic               fire,
   output logic               probe,
   output logic [STALL_W-1:0] cnt
);
   assign idle = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fire  <= 1'b0;
         probe <= 1'b0;
      end else begin
         probe <= start && probe_in;
         if (start) begin
            cnt  <= len;
            fire <= (len == '0);
         end else if (cnt != '0) begin
            cnt  <= cnt - 1'b1;
            fire <= (cnt == STALL_W'(1));
         end else begin
            fire <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fetch_stall_gate.sv
module fetch_stall_gate #(
   parameter int          PC_W         = 32,
   parameter int          SETS         = 64,
   parameter int          WAYS         = 4,
   parameter int          FETCH_W      = 4,
   parameter int          INSTR_BYTES  = 4,
   parameter int          STALL_W      = 3,
   parameter int          THRESH       = 4,
   parameter bit          SAMPLE_EN    = 1'b1,
   parameter int          SAMPLE_LIMIT = 26,
   parameter logic [15:0] SEED         = 16'hACE1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lookup_valid,
   input  logic [PC_W-1:0]    lookup_pc,
   input  logic               train_valid,
   input  logic [PC_W-1:0]    train_pc,
   input  logic [STALL_W-1:0] train_stalls,
   input  logic               train_slow,
   output logic               fetch_go,
   output logic               probe_run
);
   localparam int OFF = $clog2(FETCH_W * INSTR_BYTES);

   initial begin
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0)
         else $fatal(1, "SETS must be a power of two");
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0)
         else $fatal(1, "WAYS must be a power of two");
      assert (PC_W > OFF + $clog2(SETS))
         else $fatal(1, "PC too narrow for index");
      assert (THRESH >= 0 && THRESH < 15)
         else $fatal(1, "THRESH out of range");
      assert (SAMPLE_LIMIT >= 0 && SAMPLE_LIMIT <= 256)
         else $fatal(1, "SAMPLE_LIMIT out of range");
      assert (SEED != 16'h0)
         else $fatal(1, "SEED must be nonzero");
   end

   logic               rd_hit, rd_sure;
   logic [STALL_W-1:0] rd_vec;
   logic               accept, idle, sample;
   logic [15:0]        lfsr_q;
   logic [STALL_W-1:0] pace_cnt;
   logic [STALL_W-1:0] pace_len;

   fsg_table #(
      .SETS(SETS), .WAYS(WAYS), .PC_W(PC_W), .OFF(OFF),
      .STALL_W(STALL_W), .THRESH(THRESH)
   ) i_table (
      .clk(clk), .rst_n(rst_n),
      .rd_pc(lookup_pc), .rd_hit(rd_hit), .rd_sure(rd_sure), .rd_vec(rd_vec),
      .wr_valid(train_valid), .wr_pc(train_pc),
      .wr_stalls(train_stalls), .wr_slow(train_slow)
   );

   assign accept = lookup_valid && idle;

   generate
      if (SAMPLE_EN) begin : g_sample
         fsg_lfsr #(.LW(16), .SEED(SEED)) i_lfsr (
            .clk(clk), .rst_n(rst_n), .step(accept), .state(lfsr_q)
         );
         assign sample = ({1'b0, lfsr_q[7:0]} < 9'(SAMPLE_LIMIT));
      end else begin : g_nosample
         assign lfsr_q = SEED;
         assign sample = 1'b0;
      end
   endgenerate

   assign pace_len = (rd_sure && !sample) ? rd_vec : '0;

   fsg_pacer #(.STALL_W(STALL_W)) i_pacer (
      .clk(clk), .rst_n(rst_n),
      .start(accept), .len(pace_len), .probe_in(rd_sure && sample),
      .idle(idle), .fire(fetch_go), .probe(probe_run), .cnt(pace_cnt)
   );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
   parameter int STALL_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               accept,
   input logic               fetch_go,
   input logic               probe_run,
   input logic [STALL_W-1:0] cnt,
   input logic [15:0]        lfsr_q
);
   // R8: a probe run is itself a fetch
   assert_probe_fetches_R8: assert property (@(posedge clk) disable iff (!rst_n)
      probe_run |-> fetch_go);

   // R8: a probe follows an accepted lookup
   assert_probe_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      probe_run |-> $past(accept));

   // R7: no fetch while idle cycles remain
   assert_quiet_while_counting_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> !fetch_go);

   // R9: a running count only goes down by one, whatever lookups arrive
   assert_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> (cnt == STALL_W'($past(cnt) - 1'b1)));

   // R7: last idle cycle is followed by the fetch pulse
   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == STALL_W'(1)) |=> fetch_go);

   // R8: the LFSR moves only on accepted lookups
   assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(lfsr_q));

   // R8: the LFSR never locks up at zero
   assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != 16'h0);
endmodule

bind fetch_stall_gate fsg_checker #(.STALL_W(STALL_W)) i_fsg_checker (
   .clk(clk), .rst_n(rst_n), .accept(accept), .fetch_go(fetch_go),
   .probe_run(probe_run), .cnt(pace_cnt), .lfsr_q(lfsr_q)
);

// File: tb/test_fetch_stall_gate.sv
module test_fetch_stall_gate;
   localparam int PC_W = 32, SETS = 64, WAYS = 4, STALL_W = 3, THRESH = 4;
   localparam int OFF = 4, IDX_W = 6, LIMIT = 26;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               lookup_valid = 1'b0;
   logic [PC_W-1:0]    lookup_pc = '0;
   logic               train_valid = 1'b0;
   logic [PC_W-1:0]    train_pc = '0;
   logic [STALL_W-1:0] train_stalls = '0;
   logic               train_slow = 1'b0;
   logic               fetch_go, probe_run;

   always #10 clk = ~clk;

   fetch_stall_gate i_fetch_stall_gate (
      .clk(clk), .rst_n(rst_n),
      .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
      .train_valid(train_valid), .train_pc(train_pc),
      .train_stalls(train_stalls), .train_slow(train_slow),
      .fetch_go(fetch_go), .probe_run(probe_run)
   );

   int    errors = 0, checks = 0, probes_seen = 0;
   string cur_req = "R1";
   bit    compare_on = 1'b0;

   // ---------------- behavioural reference model ----------------
   bit        m_v    [SETS][WAYS];
   int        m_tag  [SETS][WAYS];
   int        m_vec  [SETS][WAYS];
   int        m_conf [SETS][WAYS];
   int        m_rr   [SETS];
   bit [15:0] m_lfsr;
   int        m_cnt;
   bit        m_fire, m_probe;

   int s, t, hw, fw, cf, vv, n_cnt;
   bit acc, hit, sure, smp, n_fire, n_probe;

   function automatic int set_of(logic [PC_W-1:0] pc);
      return int'((pc >> OFF) % SETS);
   endfunction
   function automatic int tag_of(logic [PC_W-1:0] pc);
      return int'(pc >> (OFF + IDX_W));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < SETS; a++) begin
            m_rr[a] = 0;
            for (int b = 0; b < WAYS; b++) begin
               m_v[a][b] = 1'b0; m_tag[a][b] = 0; m_vec[a][b] = 0; m_conf[a][b] = 0;
            end
         end
         m_lfsr = 16'hACE1; m_cnt = 0; m_fire = 1'b0; m_probe = 1'b0;
      end else begin
         acc = lookup_valid && (m_cnt == 0);
         n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
         n_fire = (m_cnt == 1);
         n_probe = 1'b0;
         if (acc) begin
            s = set_of(lookup_pc); t = tag_of(lookup_pc);
            hit = 1'b0; cf = 0; vv = 0;
            for (int b = 0; b < WAYS; b++)
               if (m_v[s][b] && m_tag[s][b] == t) begin
                  hit = 1'b1; cf = m_conf[s][b]; vv = m_vec[s][b];
               end
            sure = hit && (cf > THRESH);
            smp = (m_lfsr[7:0] < LIMIT);
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
            if (sure && !smp && vv > 0) n_cnt = vv;
            else n_fire = 1'b1;
            n_probe = sure && smp;
         end
         if (train_valid) begin
            s = set_of(train_pc); t = tag_of(train_pc); hw = -1;
            for (int b = 0; b < WAYS; b++)
               if (m_v[s][b] && m_tag[s][b] == t) hw = b;
            if (hw >= 0) begin
               if (train_slow) begin
                  m_conf[s][hw] = 0; m_vec[s][hw] = int'(train_stalls);
               end else if (m_conf[s][hw] < 15) m_conf[s][hw]++;
            end else begin
               fw = -1;
               for (int b = WAYS - 1; b >= 0; b--) if (!m_v[s][b]) fw = b;
               if (fw < 0) begin
                  fw = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % WAYS;
               end
               m_v[s][fw] = 1'b1; m_tag[s][fw] = t;
               m_vec[s][fw] = int'(train_stalls); m_conf[s][fw] = 0;
            end
         end
         m_cnt = n_cnt; m_fire = n_fire; m_probe = n_probe;
      end
   end

   // ---------------- per-cycle comparison ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (compare_on) begin
         check(fetch_go === m_fire, cur_req, "fetch_go", int'(fetch_go), int'(m_fire));
         check(probe_run === m_probe, cur_req, "probe_run", int'(probe_run), int'(m_probe));
         if (probe_run === 1'b1) probes_seen++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic look(input logic [PC_W-1:0] pc);
      lookup_valid = 1'b1; lookup_pc = pc;
      @(negedge clk);
      lookup_valid = 1'b0;
      repeat (9) @(negedge clk);
   endtask

   task automatic train(input logic [PC_W-1:0] pc, input int st, input bit slow);
      train_valid = 1'b1; train_pc = pc; train_stalls = STALL_W'(st); train_slow = slow;
      @(negedge clk);
      train_valid = 1'b0; train_slow = 1'b0;
   endtask

   // watchdog
   initial begin
      #(20 * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   localparam logic [PC_W-1:0] PA = 32'h1000;  // set 0
   localparam logic [PC_W-1:0] PB = 32'h2040;  // set 4
   int gap;

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(fetch_go === 1'b0, "R1", "fetch_go in reset", int'(fetch_go), 0);
      check(probe_run === 1'b0, "R1", "probe_run in reset", int'(probe_run), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_on = 1'b1;
      check(fetch_go === 1'b0, "R1", "fetch_go after reset", int'(fetch_go), 0);

      // R2: untrained lookup goes immediately
      cur_req = "R2"; look(PA);
      // R4: allocate, R5: bump up to threshold (4), still ungated (R2)
      cur_req = "R4"; train(PA, 3, 1'b0);
      cur_req = "R5"; repeat (4) train(PA, 3, 1'b0);
      cur_req = "R2"; look(PA);
      // R7: one more bump -> confident, gated by 3
      cur_req = "R7"; train(PA, 3, 1'b0);
      repeat (4) look(PA);
      // R3: low offset bits alias, different tag misses
      cur_req = "R3"; look(PA + 32'h8); look(PA + 32'hC); look(PA + 32'h400);
      // R9: continuous lookups while counting
      cur_req = "R9";
      lookup_valid = 1'b1; lookup_pc = PA;
      repeat (30) @(negedge clk);
      lookup_valid = 1'b0; repeat (10) @(negedge clk);
      // R6: slowdown reloads vector, clears confidence
      cur_req = "R6"; train(PA, 5, 1'b1); look(PA);
      repeat (5) train(PA, 1, 1'b0);
      look(PA); look(PA);
      // R5: saturation survives more than 16 bumps
      cur_req = "R5"; repeat (20) train(PA, 0, 1'b0);
      look(PA); look(PA);
      // R10: same-cycle lookup and slow training
      cur_req = "R10";
      lookup_valid = 1'b1; lookup_pc = PA;
      train_valid = 1'b1; train_pc = PA; train_stalls = 3'd2; train_slow = 1'b1;
      @(negedge clk);
      lookup_valid = 1'b0; train_valid = 1'b0; train_slow = 1'b0;
      repeat (9) @(negedge clk);
      look(PA);
      // R4: fill set 0 then evict by round-robin
      cur_req = "R4";
      repeat (6) train(PA, 4, 1'b0);
      train(PA + 32'h400, 2, 1'b0); train(PA + 32'h800, 2, 1'b0);
      train(PA + 32'hC00, 2, 1'b0); train(PA + 32'h1000, 2, 1'b0);
      look(PA); look(PA + 32'h1000);
      train(PA + 32'h1400, 1, 1'b0);
      look(PA + 32'h400);
      // R8: many lookups of a confident group
      cur_req = "R8";
      repeat (8) train(PB, 6, 1'b0);
      probes_seen = 0;
      repeat (300) look(PB);
      check(probes_seen > 0, "R8", "probe count", probes_seen, 1);
      // mixed traffic, crowded sets
      cur_req = "R4/R5/R6/R7 mix";
      for (int k = 0; k < 3000; k++) begin
         gap = $urandom % 6;
         lookup_valid = ($urandom % 2) == 1;
         lookup_pc = (($urandom % 2) ? PA : PB) + 32'h400 * ($urandom % 6) + ($urandom % 16);
         train_valid = ($urandom % 3) == 0;
         train_pc = (($urandom % 2) ? PA : PB) + 32'h400 * gap;
         train_stalls = STALL_W'($urandom % 8);
         train_slow = ($urandom % 8) == 0;
         @(negedge clk);
      end
      lookup_valid = 1'b0; train_valid = 1'b0; train_slow = 1'b0;
      repeat (12) @(negedge clk);
      compare_on = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule